// File: doc/BRIEF.md
# RGB to YCbCr Colour Space Converter

A pipelined converter that turns a stream of 8-bit RGB pixels into 8-bit luma and two chroma components. Pixels enter and leave through valid/ready handshakes. Each output component is a signed fractional weighted sum of R, G and B. The sum is scaled to the selected quantization range, rounded, offset and clamped.

Three coefficient words, one per output component, supply the matrix used for high-definition frames. A line-count input chooses the matrix. Frames with fewer than 720 active lines use a fixed standard-definition matrix held inside the block. Taller frames use the programmable words. A separate input chooses between full-range and limited-range output. Both choices, and the coefficient words, are taken from the inputs on the cycle the pixel is accepted and then travel with that pixel.

Top module: `csc_rgb_ycc`

## Requirements
- R1: Each coefficient word holds three 10-bit two's-complement fractions, with value = code / 512. The R weight sits in bits 29:20, the G weight in bits 19:10 and the B weight in bits 9:0. `cfg_row_y`, `cfg_row_cb` and `cfg_row_cr` drive the luma, blue-difference and red-difference rows.
- R2: When `frame_lines` is below 720, the words are ignored and a fixed matrix is used, in units of 1/512. Luma is (153, 301, 58), blue-difference is (-86, -170, 256) and red-difference is (256, -214, -42). At 720 lines or more, the words are used.
- R3: For each component, S = cR*R + cG*G + cB*B is formed exactly. The block then computes A = S * K and takes floor((A + 65536) / 131072), where K is the range scale. The offset is added to that result.
- R4: With `range_full` = 1, K is 256 for every component. Luma gets offset 0 and both chroma components get offset 128.
- R5: With `range_full` = 0, luma uses K = 220 and offset 16, and both chroma components use K = 225 and offset 128.
- R6: Every result is clamped to 0..255 after the offset is added.
- R7: With `m_ready` held high, a pixel accepted on rising edge n is presented with `m_valid` high right after rising edge n+2.
- R8: While `m_valid` is high and `m_ready` is low, the whole pipeline stalls. `s_ready` is low, and `m_valid` and all output components hold their values. When `m_valid` is low, `s_ready` is high.
- R9: Every accepted pixel yields exactly one output transfer, and outputs come out in acceptance order.
- R10: While `rst_n` is low, `m_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Converter can take a pixel |
| s_red | input | 8 | Red sample |
| s_green | input | 8 | Green sample |
| s_blue | input | 8 | Blue sample |
| cfg_row_y | input | 30 | Luma coefficient word |
| cfg_row_cb | input | 30 | Blue-difference coefficient word |
| cfg_row_cr | input | 30 | Red-difference coefficient word |
| frame_lines | input | 11 | Active line count of the current frame |
| range_full | input | 1 | 1 = full range output, 0 = limited range |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream accepts the output pixel |
| m_luma | output | 8 | Y result |
| m_cb | output | 8 | Cb result |
| m_cr | output | 8 | Cr result |

## Verification
A wrong product, sum or scale register shows up in the very output transfer that carries the affected pixel, two edges after acceptance. A wrong range flag carried in the pipeline also shows there, as a value 16 off in luma or a mis-scaled chroma. A valid bit that drops or duplicates a pixel breaks the order of the transfers, so every later comparison in the stream fails. A stall that lets one stage move puts two pixels out of step; the held output changes under a low `m_ready`, or the next transfer carries a neighbour's value. The bench therefore compares every transfer against the arithmetic result of its own pixel. It does this across both matrices, both ranges and saturating coefficient sets, under random gaps and back-pressure.

// File: rtl/csc_pkg.sv
package csc_pkg;

  localparam int NUM_CH  = 3;
  localparam int NUM_TAP = 3;

  typedef enum int {CH_Y = 0, CH_CB = 1, CH_CR = 2} chan_e;

  // Standard-definition matrix, Q9 (code / 512); tap 0 = R, 1 = G, 2 = B.
  function automatic int sd_q9(input int ch, input int tap);
    case (ch * NUM_TAP + tap)
      0:       return 153;
      1:       return 301;
      2:       return 58;
      3:       return -86;
      4:       return -170;
      5:       return 256;
      6:       return 256;
      7:       return -214;
      8:       return -42;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/csc_mtx_sel.sv
module csc_mtx_sel
  import csc_pkg::*;
#(
  parameter int COEF_W   = 10,
  parameter int LINE_W   = 11,
  parameter int HD_LINES = 720
) (
  input  logic [NUM_CH-1:0][NUM_TAP*COEF_W-1:0]         words_i,
  input  logic [LINE_W-1:0]                             lines_i,
  output logic [NUM_CH-1:0][NUM_TAP-1:0][COEF_W-1:0]    coef_o
);

  logic use_fixed;

  assign use_fixed = (lines_i < LINE_W'(HD_LINES));

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      for (genvar tap = 0; tap < NUM_TAP; tap++) begin : g_tap
        // Fixed table is Q9; widen by left shift for wider coefficients.
        localparam logic [COEF_W-1:0] FIXED =
          COEF_W'(sd_q9(ch, tap) * (1 << (COEF_W - 10)));
        // R weight occupies the most significant field of the word.
        assign coef_o[ch][tap] = use_fixed ? FIXED
                               : words_i[ch][(NUM_TAP-1-tap)*COEF_W +: COEF_W];
      end
    end
  endgenerate

endmodule

// File: rtl/csc_row.sv
module csc_row
  import csc_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 10,
  parameter int SCL_W  = PIX_W + 1,
  parameter int ACC_W  = COEF_W + PIX_W + 3 + SCL_W + 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              en,
  input  logic [NUM_TAP-1:0][COEF_W-1:0]    coef_i,
  input  logic [NUM_TAP-1:0][PIX_W-1:0]     pix_i,
  input  logic [SCL_W-1:0]                  scale_i,
  output logic signed [ACC_W-1:0]           acc_o
);

  localparam int PROD_W = COEF_W + PIX_W + 1;
  localparam int SUM_W  = PROD_W + 2;

  logic signed [PROD_W-1:0] prod_d [NUM_TAP];
  logic signed [PROD_W-1:0] prod_q [NUM_TAP];
  logic        [SCL_W-1:0]  scale_q;
  logic signed [SUM_W-1:0]  sum_d;
  logic signed [ACC_W-1:0]  acc_d;
  logic signed [ACC_W-1:0]  acc_q;

  // Stage 1: signed coefficient times unsigned sample, exact.
  always_comb begin
    for (int t = 0; t < NUM_TAP; t++) begin
      prod_d[t] = $signed(coef_i[t]) * $signed({1'b0, pix_i[t]});
    end
  end

  // Stage 2: exact sum, then multiply by the range scale.
  always_comb begin
    sum_d = '0;
    for (int t = 0; t < NUM_TAP; t++) begin
      sum_d = sum_d + SUM_W'(prod_q[t]);
    end
    acc_d = ACC_W'(sum_d) * ACC_W'($signed({1'b0, scale_q}));
  end

  always_ff @(posedge clk) begin
    if (en) begin
      for (int t = 0; t < NUM_TAP; t++) begin
        prod_q[t] <= prod_d[t];
      end
      scale_q <= scale_i;
      acc_q   <= acc_d;
    end
  end

  assign acc_o = acc_q;

  AST_ZERO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pix_i[0] == '0) |=> (prod_q[0] == '0)); // R3

endmodule

// File: rtl/csc_quant.sv
module csc_quant #(
  parameter int PIX_W = 8,
  parameter int ACC_W = 31,
  parameter int SHIFT = 17
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [ACC_W-1:0]  acc_i,
  input  logic [PIX_W-1:0]         offset_i,
  output logic [PIX_W-1:0]         q_o
);

  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(64'sd1 <<< (SHIFT - 1));
  localparam logic signed [ACC_W-1:0] TOP  = ACC_W'((1 << PIX_W) - 1);

  logic signed [ACC_W-1:0] rnd;
  logic signed [ACC_W-1:0] lvl;
  logic        [PIX_W-1:0] q_d;
  logic        [PIX_W-1:0] q_q;

  always_comb begin
    rnd = (acc_i + HALF) >>> SHIFT;
    lvl = rnd + ACC_W'($signed({1'b0, offset_i}));
    if (lvl < 0) begin
      q_d = '0;
    end else if (lvl > TOP) begin
      q_d = '1;
    end else begin
      q_d = lvl[PIX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

  AST_NEUTRAL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (en && acc_i == '0) |=> (q_q == $past(offset_i))); // R4

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (acc_i + HALF) < 0 && offset_i == '0) |=> (q_q == '0)); // R6

endmodule

// File: rtl/csc_rgb_ycc.sv
module csc_rgb_ycc
  import csc_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int COEF_W   = 10,
  parameter int LINE_W   = 11,
  parameter int HD_LINES = 720
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        s_valid,
  output logic                        s_ready,
  input  logic [PIX_W-1:0]            s_red,
  input  logic [PIX_W-1:0]            s_green,
  input  logic [PIX_W-1:0]            s_blue,
  input  logic [NUM_TAP*COEF_W-1:0]   cfg_row_y,
  input  logic [NUM_TAP*COEF_W-1:0]   cfg_row_cb,
  input  logic [NUM_TAP*COEF_W-1:0]   cfg_row_cr,
  input  logic [LINE_W-1:0]           frame_lines,
  input  logic                        range_full,
  output logic                        m_valid,
  input  logic                        m_ready,
  output logic [PIX_W-1:0]            m_luma,
  output logic [PIX_W-1:0]            m_cb,
  output logic [PIX_W-1:0]            m_cr
);

  localparam int WORD_W     = NUM_TAP * COEF_W;
  localparam int PROD_W     = COEF_W + PIX_W + 1;
  localparam int SUM_W      = PROD_W + 2;
  localparam int SCL_W      = PIX_W + 1;
  localparam int ACC_W      = SUM_W + SCL_W + 1;
  localparam int SHIFT      = (COEF_W - 1) + PIX_W;
  localparam int PIX_MAX    = (1 << PIX_W) - 1;
  localparam int FULL_K     = 1 << PIX_W;
  localparam int Y_SPAN     = 219 << (PIX_W - 8);
  localparam int C_SPAN     = 224 << (PIX_W - 8);
  localparam int Y_K        = (Y_SPAN * 2 * FULL_K + PIX_MAX) / (2 * PIX_MAX);
  localparam int C_K        = (C_SPAN * 2 * FULL_K + PIX_MAX) / (2 * PIX_MAX);
  localparam int Y_FLOOR    = 16 << (PIX_W - 8);
  localparam int C_MID      = 1 << (PIX_W - 1);

  logic                                     en;
  logic                                     v1_d, v2_d, v3_d;
  logic                                     v1_q, v2_q, v3_q;
  logic                                     rng1_q, rng2_q;
  logic [NUM_CH-1:0][WORD_W-1:0]            words;
  logic [NUM_CH-1:0][NUM_TAP-1:0][COEF_W-1:0] coef;
  logic [NUM_TAP-1:0][PIX_W-1:0]            pix;
  logic [SCL_W-1:0]                         scale_sel [NUM_CH];
  logic [PIX_W-1:0]                         offs      [NUM_CH];
  logic signed [ACC_W-1:0]                  acc       [NUM_CH];
  logic [PIX_W-1:0]                         res       [NUM_CH];

  // Global stall: every stage moves together, bubbles fill an empty output.
  assign en      = m_ready | ~v3_q;
  assign s_ready = en;

  assign words[CH_Y]  = cfg_row_y;
  assign words[CH_CB] = cfg_row_cb;
  assign words[CH_CR] = cfg_row_cr;
  assign pix[0]       = s_red;
  assign pix[1]       = s_green;
  assign pix[2]       = s_blue;

  always_comb begin
    v1_d = v1_q;
    v2_d = v2_q;
    v3_d = v3_q;
    if (en) begin
      v1_d = s_valid;
      v2_d = v1_q;
      v3_d = v2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
      v3_q <= v3_d;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      rng1_q <= range_full;
      rng2_q <= rng1_q;
    end
  end

  csc_mtx_sel #(
    .COEF_W   (COEF_W),
    .LINE_W   (LINE_W),
    .HD_LINES (HD_LINES)
  ) u_sel (
    .words_i (words),
    .lines_i (frame_lines),
    .coef_o  (coef)
  );

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_comp
      if (ch == int'(CH_Y)) begin : g_luma
        assign scale_sel[ch] = range_full ? SCL_W'(FULL_K) : SCL_W'(Y_K);
        assign offs[ch]      = rng2_q ? '0 : PIX_W'(Y_FLOOR);
      end else begin : g_chroma
        assign scale_sel[ch] = range_full ? SCL_W'(FULL_K) : SCL_W'(C_K);
        assign offs[ch]      = PIX_W'(C_MID);
      end

      csc_row #(
        .PIX_W  (PIX_W),
        .COEF_W (COEF_W),
        .SCL_W  (SCL_W),
        .ACC_W  (ACC_W)
      ) u_row (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .coef_i  (coef[ch]),
        .pix_i   (pix),
        .scale_i (scale_sel[ch]),
        .acc_o   (acc[ch])
      );

      csc_quant #(
        .PIX_W (PIX_W),
        .ACC_W (ACC_W),
        .SHIFT (SHIFT)
      ) u_quant (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .acc_i    (acc[ch]),
        .offset_i (offs[ch]),
        .q_o      (res[ch])
      );
    end
  endgenerate

  assign m_valid = v3_q;
  assign m_luma  = res[CH_Y];
  assign m_cb    = res[CH_CB];
  assign m_cr    = res[CH_CR];

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_luma) && $stable(m_cb)
                               && $stable(m_cr))); // R8

  AST_OUT_FROM_STAGE2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(v2_q)); // R7

  AST_STAGE2_FROM_STAGE1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(v2_q) |-> $past(v1_q)); // R7

endmodule

// File: tb/csc_rgb_ycc_test.sv
module csc_rgb_ycc_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        s_valid;
  logic        s_ready;
  logic [7:0]  s_red, s_green, s_blue;
  logic [29:0] cfg_row_y, cfg_row_cb, cfg_row_cr;
  logic [10:0] frame_lines;
  logic        range_full;
  logic        m_valid;
  logic        m_ready;
  logic [7:0]  m_luma, m_cb, m_cr;

  int checks = 0;
  int fails  = 0;
  logic [23:0] exp_q[$];

  localparam int NSTEP = 18;
  localparam int NPIX  = NSTEP * NSTEP * NSTEP;

  always #2 clk = ~clk;

  csc_rgb_ycc uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_valid     (s_valid),
    .s_ready     (s_ready),
    .s_red       (s_red),
    .s_green     (s_green),
    .s_blue      (s_blue),
    .cfg_row_y   (cfg_row_y),
    .cfg_row_cb  (cfg_row_cb),
    .cfg_row_cr  (cfg_row_cr),
    .frame_lines (frame_lines),
    .range_full  (range_full),
    .m_valid     (m_valid),
    .m_ready     (m_ready),
    .m_luma      (m_luma),
    .m_cb        (m_cb),
    .m_cr        (m_cr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [29:0] pack3(input int a, input int b, input int c);
    return 30'(((a & 1023) << 20) | ((b & 1023) << 10) | (c & 1023));
  endfunction

  function automatic int sd_tab(input int ch, input int tap);
    int t [9] = '{153, 301, 58, -86, -170, 256, 256, -214, -42};
    return t[ch * 3 + tap];
  endfunction

  // R1: field t of a word sits at bit 20 - 10*t, two's complement over 10 bits.
  function automatic int field(input logic [29:0] w, input int tap);
    int v;
    v = int'((w >> (20 - 10 * tap)) & 30'h3ff);
    if (v >= 512) v = v - 1024;
    return v;
  endfunction

  function automatic int model(input int ch, input int r, input int g, input int b);
    int c [3];
    int sum, k, off, acc, v;
    logic [29:0] w;
    w = (ch == 0) ? cfg_row_y : (ch == 1) ? cfg_row_cb : cfg_row_cr;
    for (int t = 0; t < 3; t++) begin
      c[t] = (frame_lines < 11'd720) ? sd_tab(ch, t) : field(w, t);
    end
    sum = c[0] * r + c[1] * g + c[2] * b;
    if (range_full) k = 256;
    else            k = (ch == 0) ? 220 : 225;
    if (ch == 0) off = range_full ? 0 : 16;
    else         off = 128;
    acc = sum * k;
    v = ((acc + 65536) >>> 17) + off;
    if (v < 0)   v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  function automatic logic [23:0] expect3(input int r, input int g, input int b);
    return {8'(model(0, r, g, b)), 8'(model(1, r, g, b)), 8'(model(2, r, g, b))};
  endfunction

  task automatic run_cfg(input string tag, input int lines, input bit full);
    int n;
    int got;
    bit hold;
    logic [23:0] held;
    logic [23:0] e;
    n = 0; got = 0; hold = 1'b0; held = '0;
    frame_lines = 11'(lines);
    range_full  = full;
    while (n < NPIX || exp_q.size() > 0) begin
      @(negedge clk);
      s_valid = (n < NPIX) && ($urandom_range(0, 3) != 0);
      s_red   = 8'((n / (NSTEP * NSTEP)) * 15);
      s_green = 8'(((n / NSTEP) % NSTEP) * 15);
      s_blue  = 8'((n % NSTEP) * 15);
      m_ready = ($urandom_range(0, 3) != 0);
      #1;
      if (hold) begin
        check(m_valid && {m_luma, m_cb, m_cr} == held, "R8", "held output",
              int'({m_valid, m_luma, m_cb, m_cr}), int'({1'b1, held}));
      end
      if (m_valid && !m_ready) begin
        check(!s_ready, "R8", "s_ready under stall", int'(s_ready), 0);
      end
      if (s_valid && s_ready) begin
        exp_q.push_back(expect3(int'(s_red), int'(s_green), int'(s_blue)));
        n++;
      end
      if (m_valid && m_ready) begin
        got++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected output", int'({m_luma, m_cb, m_cr}), 0);
        end else begin
          e = exp_q.pop_front();
          check({m_luma, m_cb, m_cr} == e, tag, "pixel", int'({m_luma, m_cb, m_cr}),
                int'(e));
        end
      end
      hold = m_valid && !m_ready;
      held = {m_luma, m_cb, m_cr};
    end
    check(got == NPIX, "R9", "output count", got, NPIX);
  endtask

  task automatic latency_probe();
    int k;
    logic [23:0] e;
    frame_lines = 11'd1080;
    range_full  = 1'b1;
    @(negedge clk);
    s_valid = 1'b1; s_red = 8'd255; s_green = 8'd0; s_blue = 8'd0; m_ready = 1'b1;
    #1;
    check(s_ready, "R8", "s_ready with empty output", int'(s_ready), 1);
    e = expect3(255, 0, 0);
    k = 0;
    do begin
      @(negedge clk);
      s_valid = 1'b0;
      #1;
      k++;
    end while (!m_valid && k < 8);
    check(k == 3, "R7", "latency in edges", k, 3);
    check({m_luma, m_cb, m_cr} == e, "R7", "probe value", int'({m_luma, m_cb, m_cr}),
          int'(e));
    @(negedge clk);
    #1;
    check(!m_valid, "R9", "single transfer", int'(m_valid), 0);
  endtask

  initial begin
    rst_n = 1'b0; s_valid = 1'b0; m_ready = 1'b0;
    s_red = '0; s_green = '0; s_blue = '0;
    frame_lines = 11'd480; range_full = 1'b1;
    cfg_row_y  = pack3(94, 314, 32);
    cfg_row_cb = pack3(-52, -173, 225);
    cfg_row_cr = pack3(225, -204, -20);
    repeat (3) @(negedge clk);
    #1;
    check(!m_valid, "R10", "m_valid in reset", int'(m_valid), 0);
    check(s_ready, "R8", "s_ready in reset", int'(s_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    latency_probe();
    run_cfg("R2/R4", 480, 1'b1);
    run_cfg("R2/R5", 719, 1'b0);
    run_cfg("R1/R4", 720, 1'b1);
    run_cfg("R1/R5", 1080, 1'b0);
    cfg_row_y  = pack3(511, 511, 511);
    cfg_row_cb = pack3(-512, -512, -512);
    cfg_row_cr = pack3(511, -512, 0);
    run_cfg("R3/R6", 2047, 1'b1);
    run_cfg("R3/R5/R6", 900, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule